// File: doc/BRIEF.md
# Serial memory status-register write-protection controller

This block holds the status register of a serial nonvolatile memory that takes commands over an SPI-style link. A byte-level front end delivers received bytes with a strobe, a flag that says whether bits of an unfinished byte are pending, and the raw chip-select level. The block decodes the write-enable command (0x06) and the write-status command (0x01). It keeps the write-enable latch, the two block-protect bits and the register-write-disable bit, and it samples the active-low hardware write-protect pin.

A command takes effect only when chip select rises while no partial byte is pending. An accepted status write starts a self-timed busy period of a parameterised number of clock cycles. The new protect values are committed when that period ends, and the write-enable latch is cleared at the same time. The status byte is always presented for a read-status (0x05) response: bit 7 register-write-disable, bits 6:4 zero, bits 3:2 block-protect, bit 1 write-enable latch, bit 0 write-in-progress. The protect code also goes to the memory array on its own port.

Top module: `sr_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and the block-protect output is 0.
- R2: A chip-select window holding exactly the single byte 0x06, closed on a byte boundary, sets the write-enable latch (status bit 1) in the clock edge that sees chip select high.
- R3: If chip select rises while the partial-byte flag is 1, the command has no effect: no latch change and no busy period.
- R4: A window of opcode 0x01 followed by at least one data byte, closed on a byte boundary while idle, starts a busy period when the latch is 1 and either the disable bit is 0 or the write-protect pin is high. Status bit 0 then reads 1 for exactly BUSY_CYCLES clock cycles, starting with the edge that sees chip select rise.
- R5: During the busy period, status bits 7 and 3:2 keep their old values. The values from the data byte appear in the cycle in which bit 0 falls.
- R6: The status write takes data bit 7 as the disable bit and data bits 3:2 as block-protect, and ignores data bits 6:4 and 1:0. Status bits 6:4 always read 0.
- R7: The write-enable latch reads 0 once the busy period ends.
- R8: A status write with the latch at 0 starts no busy period and leaves the status byte unchanged.
- R9: With the disable bit at 1 and the write-protect pin low, a status write starts no busy period, changes no bit, and leaves the latch at 1.
- R10: While status bit 0 is 1, write-enable and status-write commands are ignored.
- R11: The block-protect output always equals status bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| partial_i | input | 1 | Front end holds bits of an unfinished byte |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| rx_valid_i | input | 1 | Strobe for one received byte |
| rx_byte_i | input | 8 | Received byte |
| status_o | output | 8 | Status byte for read-status responses |
| bp_code_o | output | 2 | Block-protect code for the memory array |

## Verification
If the busy counter is loaded wrongly, status bit 0 falls early or late. The edge in which it falls is checked exactly, on the first status write. A wrong pending copy of the protect bits, or a commit made at the wrong time, shows up in bits 7 and 3:2 either during the busy window or in the cycle it ends. A wrong gating decision shows up one cycle after chip select rises, either as an unexpected busy bit or as a missing one. A sweep over data patterns and pin levels, checked against a running model, catches wrong bit positions and wrong protection conditions within a few commands.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;
  localparam logic [7:0] OP_WR_EN   = 8'h06;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam int unsigned POS_DIS   = 7;
  localparam int unsigned POS_BP_HI = 3;
  localparam int unsigned POS_BP_LO = 2;
  localparam int unsigned BP_W      = POS_BP_HI - POS_BP_LO + 1;
endpackage

// File: rtl/sr_cmd_track.sv
module sr_cmd_track
  import sr_wp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            cs_n_i,
  input  logic            partial_i,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_byte_i,
  output logic            end_o,
  output logic [7:0]      opcode_o,
  output logic [1:0]      nbytes_o,
  output logic            d_dis_o,
  output logic [BP_W-1:0] d_bp_o
);
  logic cs_prev;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cs_prev  <= 1'b1;
      nbytes_o <= '0;
      opcode_o <= '0;
      d_dis_o  <= 1'b0;
      d_bp_o   <= '0;
    end else begin
      cs_prev <= cs_n_i;
      if (cs_n_i) begin
        nbytes_o <= '0;
      end else if (rx_valid_i) begin
        if (nbytes_o != 2'd3) nbytes_o <= nbytes_o + 2'd1;
        if (nbytes_o == 2'd0) opcode_o <= rx_byte_i;
        if (nbytes_o == 2'd1) begin
          d_dis_o <= rx_byte_i[POS_DIS];
          d_bp_o  <= rx_byte_i[POS_BP_HI:POS_BP_LO];
        end
      end
    end
  end

  // window closes on a byte boundary
  assign end_o = cs_n_i & ~cs_prev & ~partial_i;
endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt    <= CW'(BUSY_CYCLES - 1);
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt == '0);
endmodule

// File: rtl/sr_wp_ctrl.sv
module sr_wp_ctrl
  import sr_wp_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1000
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       cs_n_i,
  input  logic       partial_i,
  input  logic       wp_n_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  output logic [7:0] status_o,
  output logic [1:0] bp_code_o
);
  logic            cmd_end;
  logic [7:0]      opcode;
  logic [1:0]      nbytes;
  logic            d_dis;
  logic [BP_W-1:0] d_bp;
  logic            busy, done;
  logic            wel, dis_bit, pend_dis;
  logic [BP_W-1:0] bp_bits, pend_bp;
  logic            wren_go, wrsr_go, hw_locked;

  sr_cmd_track u_track (
    .clk_i(clk_i), .rst_i(rst_i), .cs_n_i(cs_n_i), .partial_i(partial_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .end_o(cmd_end),
    .opcode_o(opcode), .nbytes_o(nbytes), .d_dis_o(d_dis), .d_bp_o(d_bp)
  );

  sr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(wrsr_go),
    .busy_o(busy), .done_o(done)
  );

  assign hw_locked = dis_bit && !wp_n_i;
  assign wren_go = cmd_end && !busy && (opcode == OP_WR_EN) && (nbytes == 2'd1);
  assign wrsr_go = cmd_end && !busy && (opcode == OP_WR_STAT) && (nbytes >= 2'd2)
                   && wel && !hw_locked;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wel      <= 1'b0;
      dis_bit  <= 1'b0;
      bp_bits  <= '0;
      pend_dis <= 1'b0;
      pend_bp  <= '0;
    end else begin
      if (wren_go) wel <= 1'b1;
      if (wrsr_go) begin
        pend_dis <= d_dis;
        pend_bp  <= d_bp;
      end
      if (done) begin
        dis_bit <= pend_dis;
        bp_bits <= pend_bp;
        wel     <= 1'b0;
      end
    end
  end

  assign status_o  = {dis_bit, 3'b000, bp_bits, wel, busy};
  assign bp_code_o = bp_bits;
endmodule

// File: rtl/sr_wp_ctrl_chk.sv
module sr_wp_ctrl_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       cs_n_i,
  input logic       partial_i,
  input logic       wp_n_i,
  input logic [7:0] status_i
);
  logic wip;
  assign wip = status_i[0];

  a_r3_start_on_boundary: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(wip) |-> $past(cs_n_i && !partial_i));

  a_r8_start_needs_wel: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(wip) |-> $past(status_i[1]));

  a_r9_hw_lock_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(wip) |-> !$past(status_i[7] && !wp_n_i));

  a_r7_wel_cleared: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(wip) |-> !status_i[1]);

  a_r5_commit_at_end: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable({status_i[7], status_i[3:2]}) |-> $fell(wip));

  a_r10_no_wren_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    (wip && $past(wip)) |-> !$rose(status_i[1]));
endmodule

bind sr_wp_ctrl sr_wp_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .cs_n_i(cs_n_i), .partial_i(partial_i),
  .wp_n_i(wp_n_i), .status_i(status_o)
);

// File: tb/sr_wp_ctrl_tb.sv
module sr_wp_ctrl_tb_top;
  localparam int unsigned BUSY = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, partial = 1'b0, wp_n = 1'b1, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] status;
  logic [1:0] bp_code;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sr_wp_ctrl #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk_i(clk), .rst_i(rst), .cs_n_i(cs_n), .partial_i(partial),
    .wp_n_i(wp_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .status_o(status), .bp_code_o(bp_code)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // closes chip select at a negedge; returns just after the edge that sees it high
  task automatic send(input logic [7:0] b0, input logic [7:0] b1, input int n, input bit part);
    @(negedge clk) cs_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk) rx_valid = 1'b1; rx_byte = (k == 0) ? b0 : b1;
    end
    @(negedge clk) rx_valid = 1'b0; partial = part; cs_n = 1'b1;
    @(negedge clk) partial = 1'b0;
  endtask

  task automatic busy_run(input logic [7:0] old_s, input logic [7:0] new_s);
    for (int c = 0; c < int'(BUSY); c++) begin
      chk("R4 busy window", status, old_s | 8'h01);
      chk("R5 old values held", {status[7], 3'b000, status[3:2], 2'b00},
          {old_s[7], 3'b000, old_s[3:2], 2'b00});
      @(negedge clk);
    end
    chk("R5 R7 committed at end", status, new_s);
    chk("R11 bp port", {6'd0, bp_code}, {6'd0, new_s[3:2]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R4 watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic m_dis, m_wel;
    logic [1:0] m_bp;
    logic [7:0] d, exp_s;
    bit ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset bp", {6'd0, bp_code}, 8'h00);

    send(8'h01, 8'h0C, 2, 0);
    chk("R8 no wel no busy", status, 8'h00);
    repeat (3) @(negedge clk);
    chk("R8 still unchanged", status, 8'h00);

    send(8'h06, 8'h00, 1, 1);
    chk("R3 partial wren ignored", status, 8'h00);
    send(8'h06, 8'h00, 1, 0);
    chk("R2 wren sets latch", status, 8'h02);
    send(8'h01, 8'h8C, 2, 1);
    chk("R3 partial wrsr no busy", status, 8'h02);

    send(8'h01, 8'hFF, 2, 0);
    busy_run(8'h02, 8'h8C);
    chk("R6 bits 6:4 zero", {5'd0, status[6:4]}, 8'h00);

    wp_n = 1'b0;
    send(8'h06, 8'h00, 1, 0);
    chk("R2 wren again", status, 8'h8E);
    send(8'h01, 8'h00, 2, 0);
    chk("R9 hw locked rejected", status, 8'h8E);
    repeat (3) @(negedge clk);
    chk("R9 latch kept", status, 8'h8E);

    wp_n = 1'b1;
    send(8'h01, 8'h00, 2, 0);
    busy_run(8'h8E, 8'h00);

    send(8'h06, 8'h00, 1, 0);
    send(8'h01, 8'h0C, 2, 0);
    chk("R10 busy started", status, 8'h03);
    send(8'h06, 8'h00, 1, 0);
    send(8'h01, 8'h80, 2, 0);
    ok = 0;
    for (int w = 0; w < 40 && !ok; w++) begin
      if (status[0] == 1'b0) ok = 1; else @(negedge clk);
    end
    chk("R10 commands ignored while busy", status, 8'h0C);
    repeat (15) @(negedge clk);
    chk("R10 no second busy", status, 8'h0C);

    m_dis = 1'b0; m_bp = 2'd3; m_wel = 1'b0;
    for (int i = 0; i < 32; i++) begin
      d = {i[2], 3'(i * 5 + 1), i[1:0], 2'(i * 3 + 2)};
      wp_n = i[3] ^ i[4];
      send(8'h06, 8'h00, 1, 0);
      m_wel = 1'b1;
      exp_s = {m_dis, 3'b000, m_bp, m_wel, 1'b0};
      chk("R2 sweep wren", status, exp_s);
      send(8'h01, d, 2, 0);
      if (!(m_dis && !wp_n)) begin
        m_dis = d[7]; m_bp = d[3:2]; m_wel = 1'b0;
        busy_run(exp_s, {m_dis, 3'b000, m_bp, 2'b00});
      end else begin
        chk("R9 sweep rejected", status, exp_s);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule